// File: doc/BRIEF.md
# Long Integer Multiply Unit

This unit is an iterative 32x32 multiplier for an integer datapath. A single engine serves five operations chosen by a 3-bit opcode: a plain multiply that keeps the low word, a multiply with a 32-bit addend, an unsigned long multiply, a signed long multiply, and an unsigned long multiply with a 64-bit addend. The long forms return their 64-bit result as two separate 32-bit words, each with its own write-enable, so that the surrounding pipeline can retire them to two destinations.

One operation is in flight at a time. The caller raises `start` for one or more cycles with the opcode and operands. The unit takes them on the first edge at which it is idle, runs a radix-2 shift-add over 32 steps on the operand magnitudes, then spends one finishing cycle applying the sign and the addend. It pulses `done` together with the write-enables. Opcodes that the unit does not implement are reported through a flag, and nothing is written for them.

Top module: `lmul_unit`

## Requirements
- R1: While reset is held and at the first edge after it is released, `busy`, `done`, `wr_lo`, `wr_hi` and `unimpl` are all 0.
- R2: Opcode 3'd0 (plain multiply) sets `res_lo` to bits 31:0 of a*b and `res_hi` to 0, with `wr_lo`=1 and `wr_hi`=0.
- R3: Opcode 3'd1 (multiply with addend) sets `res_lo` to (a*b + acc_lo) mod 2^32 and `res_hi` to 0, with `wr_lo`=1 and `wr_hi`=0.
- R4: Opcode 3'd4 (unsigned long) zero-extends both operands. `res_lo` receives product bits 31:0 and `res_hi` receives bits 63:32, and `wr_lo` and `wr_hi` are both 1.
- R5: Opcode 3'd6 (signed long) sign-extends both operands from bit 31 and splits the 64-bit two's-complement product as in R4.
- R6: Opcode 3'd7 (unsigned long with addend) adds {acc_hi, acc_lo} to the unsigned 64-bit product modulo 2^64 and splits the sum as in R4.
- R7: Opcodes 3'd2, 3'd3 and 3'd5 are reserved. They complete with `unimpl`=1, `wr_lo`=`wr_hi`=0, and `res_lo`/`res_hi` keep their previous values.
- R8: `start` is accepted at a rising edge where `busy` is 0. For a legal opcode, `busy` is 1 from that edge until the 33rd edge after it, and `done` is 1 for the cycle that follows that edge. For a reserved opcode, `done` follows the first edge after acceptance.
- R9: While `busy` is 1, `start` is ignored. Changes to `op`, `src_a`, `src_b`, `acc_hi` and `acc_lo` after acceptance do not alter the result.
- R10: `done` never stays high two cycles in a row. `wr_lo`, `wr_hi` and `unimpl` are 0 whenever `done` is 0, and `wr_hi` implies `wr_lo`.
- R11: A `start` held high during the `done` cycle is accepted at the next edge, so operations can run back to back without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| op | input | 3 | Operation code (see R2 to R7) |
| src_a | input | 32 | First multiplicand |
| src_b | input | 32 | Second multiplicand |
| acc_hi | input | 32 | High word of the addend (opcode 7 only) |
| acc_lo | input | 32 | Low word of the addend (opcodes 1 and 7) |
| busy | output | 1 | Operation in flight; start ignored |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word |
| wr_lo | output | 1 | Low word valid, qualified by done |
| wr_hi | output | 1 | High word valid, qualified by done |
| unimpl | output | 1 | Reserved opcode completed, qualified by done |

## Verification
Completion and a new acceptance can share a cycle. The `done` pulse of one operation arrives while `start` for the next is already high, and the unit must retire the first result and accept the second at the very next edge without pulsing `done` twice. The bench produces this on every operation, because its driver raises `start` in the same cycle in which its model predicts `done`. A behavioural countdown model predicts `busy` and `done` on every clock and flags any extra or missing pulse. A second overlap is also provoked: `start` is held high with a reserved opcode and fresh operands while a multiply is still running. The result is then judged against the values captured at acceptance.

// File: rtl/lmul_pkg.sv
package lmul_pkg;

  localparam logic [2:0] OPC_MUL   = 3'd0;
  localparam logic [2:0] OPC_MLA   = 3'd1;
  localparam logic [2:0] OPC_UMULL = 3'd4;
  localparam logic [2:0] OPC_SMULL = 3'd6;
  localparam logic [2:0] OPC_UMLAL = 3'd7;

  typedef enum logic [1:0] {
    ADD_NONE = 2'd0,
    ADD_LOW  = 2'd1,
    ADD_FULL = 2'd2
  } addend_e;

  typedef struct packed {
    logic    legal;
    logic    sgn;
    logic    wide;
    addend_e addend;
  } mul_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;

endpackage

// File: rtl/lmul_decode.sv
module lmul_decode
  import lmul_pkg::*;
(
  input  logic [2:0] op,
  output mul_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{legal: 1'b0, sgn: 1'b0, wide: 1'b0, addend: ADD_NONE};
    case (op)
      OPC_MUL:   ctrl = '{legal: 1'b1, sgn: 1'b0, wide: 1'b0, addend: ADD_NONE};
      OPC_MLA:   ctrl = '{legal: 1'b1, sgn: 1'b0, wide: 1'b0, addend: ADD_LOW};
      OPC_UMULL: ctrl = '{legal: 1'b1, sgn: 1'b0, wide: 1'b1, addend: ADD_NONE};
      OPC_SMULL: ctrl = '{legal: 1'b1, sgn: 1'b1, wide: 1'b1, addend: ADD_NONE};
      OPC_UMLAL: ctrl = '{legal: 1'b1, sgn: 1'b0, wide: 1'b1, addend: ADD_FULL};
      default:   ctrl = '{legal: 1'b0, sgn: 1'b0, wide: 1'b0, addend: ADD_NONE};
    endcase
  end

endmodule

// File: rtl/lmul_shiftadd.sv
module lmul_shiftadd #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod,
  output logic           running,
  output logic           last_step
);

  localparam int DW = 2 * W;
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [DW-1:0] acc_q;
  logic [W-1:0]  mcand_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  // One radix-2 step: add multiplicand into the upper half when the
  // current multiplier bit is set, then shift the whole register right.
  function automatic logic [DW-1:0] step_fn(input logic [DW-1:0] a,
                                            input logic [W-1:0]  m);
    logic [W:0] s;
    s = {1'b0, a[DW-1:W]} + (a[0] ? {1'b0, m} : {(W+1){1'b0}});
    return {s, a[W-1:1]};
  endfunction

  assign last_step = run_q && (cnt_q == CW'(W-1));
  assign running   = run_q;
  assign prod      = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
    end else if (load) begin
      acc_q   <= {{W{1'b0}}, mplier};
      mcand_q <= mcand;
      cnt_q   <= '0;
      run_q   <= 1'b1;
    end else if (run_q) begin
      acc_q <= step_fn(acc_q, mcand_q);
      cnt_q <= cnt_q + 1'b1;
      if (last_step) run_q <= 1'b0;
    end
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !last_step && !load) |=> (run_q && cnt_q == $past(cnt_q) + 1'b1)); // R8

  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && !load) |=> !run_q); // R8

endmodule

// File: rtl/lmul_finish.sv
module lmul_finish
  import lmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] prod,
  input  logic           negate,
  input  mul_ctrl_t      ctrl,
  input  logic [W-1:0]   add_hi,
  input  logic [W-1:0]   add_lo,
  output logic [W-1:0]   out_lo,
  output logic [W-1:0]   out_hi
);

  localparam int DW = 2 * W;

  // Sign correction followed by the addend selected by the opcode.
  function automatic logic [DW-1:0] finish_fn(input logic [DW-1:0] p,
                                              input logic          neg,
                                              input addend_e       mode,
                                              input logic          wide,
                                              input logic [W-1:0]  ahi,
                                              input logic [W-1:0]  alo);
    logic [DW-1:0] s;
    logic [W-1:0]  lo;
    s = neg ? (~p + 1'b1) : p;
    case (mode)
      ADD_LOW:  begin
        lo = s[W-1:0] + alo;
        s  = {s[DW-1:W], lo};
      end
      ADD_FULL: s = s + {ahi, alo};
      default:  s = s;
    endcase
    if (!wide) s[DW-1:W] = '0;
    return s;
  endfunction

  logic [DW-1:0] fin;
  assign fin    = finish_fn(prod, negate, ctrl.addend, ctrl.wide, add_hi, add_lo);
  assign out_lo = fin[W-1:0];
  assign out_hi = fin[DW-1:W];

endmodule

// File: rtl/lmul_unit.sv
module lmul_unit
  import lmul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] acc_lo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         wr_lo,
  output logic         wr_hi,
  output logic         unimpl
);

  localparam int DW = 2 * W;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x,
                                             input logic         sgn);
    return (sgn && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  mul_state_e    state_q;
  mul_ctrl_t     ctrl_in;
  mul_ctrl_t     ctrl_q;
  logic          neg_q;
  logic [W-1:0]  add_hi_q;
  logic [W-1:0]  add_lo_q;
  logic          accept;
  logic          eng_load;
  logic          eng_running;
  logic          eng_last;
  logic [DW-1:0] eng_prod;
  logic [W-1:0]  fin_lo;
  logic [W-1:0]  fin_hi;

  assign accept   = start && (state_q == ST_IDLE);
  assign eng_load = accept && ctrl_in.legal;
  assign busy     = (state_q != ST_IDLE);

  lmul_decode u_decode (
    .op   (op),
    .ctrl (ctrl_in)
  );

  lmul_shiftadd #(.W(W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (eng_load),
    .mcand     (magnitude(src_a, ctrl_in.sgn)),
    .mplier    (magnitude(src_b, ctrl_in.sgn)),
    .prod      (eng_prod),
    .running   (eng_running),
    .last_step (eng_last)
  );

  lmul_finish #(.W(W)) u_finish (
    .prod   (eng_prod),
    .negate (neg_q),
    .ctrl   (ctrl_q),
    .add_hi (add_hi_q),
    .add_lo (add_lo_q),
    .out_lo (fin_lo),
    .out_hi (fin_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ctrl_q   <= '0;
      neg_q    <= 1'b0;
      add_hi_q <= '0;
      add_lo_q <= '0;
      res_lo   <= '0;
      res_hi   <= '0;
      done     <= 1'b0;
      wr_lo    <= 1'b0;
      wr_hi    <= 1'b0;
      unimpl   <= 1'b0;
    end else begin
      done   <= 1'b0;
      wr_lo  <= 1'b0;
      wr_hi  <= 1'b0;
      unimpl <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          ctrl_q   <= ctrl_in;
          neg_q    <= ctrl_in.sgn && (src_a[W-1] ^ src_b[W-1]);
          add_hi_q <= acc_hi;
          add_lo_q <= acc_lo;
          state_q  <= ctrl_in.legal ? ST_RUN : ST_FIN;
        end
        ST_RUN: if (eng_last) state_q <= ST_FIN;
        ST_FIN: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
          if (ctrl_q.legal) begin
            res_lo <= fin_lo;
            res_hi <= fin_hi;
            wr_lo  <= 1'b1;
            wr_hi  <= ctrl_q.wide;
          end else begin
            unimpl <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !wr_lo && !wr_hi && !unimpl)); // R1

  AST_WIDE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> wr_lo); // R4

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl |-> (!wr_lo && !wr_hi && $stable(res_lo) && $stable(res_hi))); // R7

  AST_ENGINE_TRACKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> eng_running); // R8

  AST_DONE_FROM_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state_q) == ST_FIN)); // R8

  AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_q)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi || unimpl) |-> done); // R10

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> busy); // R11

endmodule

// File: tb/test_lmul_unit.sv
module test_lmul_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int LAT_LEGAL  = 33;
  localparam int LAT_RESVD  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] src_a = '0, src_b = '0, acc_hi = '0, acc_lo = '0;
  logic        busy, done, wr_lo, wr_hi, unimpl;
  logic [31:0] res_lo, res_hi;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  lmul_unit i_lmul_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .unimpl(unimpl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  int          m_cnt = 0;
  bit          m_done = 0;
  logic [31:0] m_lo = '0, m_hi = '0;
  bit          m_wlo = 0, m_whi = 0, m_unimpl = 0;
  logic [31:0] p_lo = '0, p_hi = '0;
  bit          p_wlo = 0, p_whi = 0, p_unimpl = 0;
  string       cur_tag = "R2";
  string       m_tag = "R2";
  string       p_tag = "R2";

  function automatic logic [63:0] ref_result(input logic [2:0] o,
      input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] h, input logic [31:0] l);
    logic [63:0] ua, ub, sa, sb, r;
    ua = {32'd0, a};
    ub = {32'd0, b};
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (o)
      3'd0: r = {32'd0, 32'(ua * ub)};
      3'd1: r = {32'd0, 32'(ua * ub) + l};
      3'd4: r = ua * ub;
      3'd6: r = sa * sb;
      3'd7: r = ua * ub + {h, l};
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_wlo = 0; m_whi = 0; m_unimpl = 0;
      m_lo = '0; m_hi = '0;
    end else begin
      m_done = 0; m_wlo = 0; m_whi = 0; m_unimpl = 0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_done = 1; m_wlo = p_wlo; m_whi = p_whi; m_unimpl = p_unimpl;
          m_tag = p_tag;
          if (!p_unimpl) begin m_lo = p_lo; m_hi = p_hi; end
        end
      end else if (start) begin
        logic [63:0] r;
        bit legal;
        legal = (op == 3'd0) || (op == 3'd1) || (op == 3'd4) || (op == 3'd6) || (op == 3'd7);
        r = ref_result(op, src_a, src_b, acc_hi, acc_lo);
        p_lo = r[31:0]; p_hi = r[63:32];
        p_wlo = legal; p_whi = legal && op[2]; p_unimpl = !legal;
        p_tag = cur_tag;
        m_cnt = legal ? LAT_LEGAL : LAT_RESVD;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst_n) begin
      check(!busy && !done && !wr_lo && !wr_hi && !unimpl, "R1", "reset outputs",
            {59'd0, busy, done, wr_lo, wr_hi, unimpl}, 64'd0);
    end else begin
      check(busy == (m_cnt > 0), "R8", "busy", 64'(busy), 64'(m_cnt > 0));
      check(done == m_done, "R8", "done", 64'(done), 64'(m_done));
      if (!m_done)
        check(!wr_lo && !wr_hi && !unimpl, "R10", "flags outside done",
              {61'd0, wr_lo, wr_hi, unimpl}, 64'd0);
      if (m_done && done) begin
        check({wr_lo, wr_hi, unimpl} == {m_wlo, m_whi, m_unimpl}, m_tag, "write flags",
              {61'd0, wr_lo, wr_hi, unimpl}, {61'd0, m_wlo, m_whi, m_unimpl});
        check({res_hi, res_lo} == {m_hi, m_lo}, m_tag, "result",
              {res_hi, res_lo}, {m_hi, m_lo});
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] h, input logic [31:0] l, input string tag);
    while (m_cnt > 1) @(negedge clk);
    if (m_cnt == 1) @(negedge clk);
    cur_tag = tag;
    op = o; src_a = a; src_b = b; acc_hi = h; acc_lo = l;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd4: return "R4";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] pick(input int sel);
    case (sel)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [2:0] legal_ops [5];
    legal_ops = '{3'd0, 3'd1, 3'd4, 3'd6, 3'd7};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // Corner operands on every legal opcode
    for (int o = 0; o < 5; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          if ((i + j) % 3 == 0 || i == j)
            issue(legal_ops[o], pick(i), pick(j), 32'hFFFF_FFFF, 32'hFFFF_FFFF, tag_of(legal_ops[o]));

    // Reserved opcodes, including back to back with each other
    issue(3'd2, 32'h1234_5678, 32'h9, 32'h1, 32'h2, "R7");
    issue(3'd5, 32'h7, 32'h7, 32'h0, 32'h0, "R7");
    issue(3'd3, 32'hFFFF_FFFF, 32'h2, 32'h0, 32'h0, "R7");

    // Explicit back-to-back pair: the second start sits in the done cycle
    issue(3'd4, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h0, 32'h0, "R4");
    issue(3'd6, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, "R11");

    // Inputs disturbed while busy: start ignored, operands held
    issue(3'd7, 32'hCAFE_0001, 32'h1357_9BDF, 32'hFFFF_FFFF, 32'hFFFF_FFF0, "R9");
    for (int k = 0; k < 10; k++) begin
      start = 1'b1; op = 3'd2; src_a = $urandom; src_b = $urandom;
      acc_hi = $urandom; acc_lo = $urandom;
      @(negedge clk);
    end
    start = 1'b0;

    // Random operands over legal and reserved opcodes
    for (int n = 0; n < 60; n++) begin
      logic [2:0] o;
      o = (n % 9 == 8) ? 3'd5 : legal_ops[$urandom_range(0, 4)];
      issue(o, pick($urandom_range(0, 7)), pick($urandom_range(0, 7)),
            $urandom, $urandom, tag_of(o));
    end

    while (m_cnt > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule